// File: doc/BRIEF.md
# Slewing CPU Frequency Selector

This block chooses the frequency setting for a CPU clock synthesizer and walks that setting to each new value in small steps, so that a PLL further downstream stays locked while the rate changes. A 3-bit select input indexes a table of eight configured frequency codes. The chosen entry is clamped to the legal range and becomes the target. The applied code then moves toward the target by one unit on each tick of a programmable step-rate divider. The synthesizer itself lies outside this block. Codes are plain integers in fixed frequency units. With the default limits, one unit is 1 MHz and the range is 8 to 100.

The control is a four-state machine. `ST_INIT` is held during reset. On the first clock after reset, the block copies the clamped target straight into the applied code and takes `ST_INIT -> ST_HOLD`. `ST_HOLD` is the idle state. It takes `ST_HOLD -> ST_RISE` when the target is above the applied code and `ST_HOLD -> ST_FALL` when the target is below it. `ST_RISE` and `ST_FALL` step the code on each tick. When the code meets the target they return to `ST_HOLD` (`ST_RISE -> ST_HOLD`, `ST_FALL -> ST_HOLD`). When the target moves to the other side of the code they swap with each other (`ST_RISE -> ST_FALL`, `ST_FALL -> ST_RISE`).

Top module: `cpu_slew_selector`

## Requirements
- R1: While reset is high, `freq_code_o` equals the lower limit (8), `slewing_o` is 0 and `settled_o` is 0.
- R2: After the first clock edge with reset low, `freq_code_o` equals the clamped target of the current select, without ramping. `settled_o` rises one cycle after that.
- R3: Table entry k occupies bits `[k*CODE_W +: CODE_W]` of `freq_table_i`. An entry below the lower limit is used as the lower limit, and an entry above the upper limit is used as the upper limit.
- R4: A select change is registered on the next edge and takes effect even during a ramp. The ramp continues from the present code and does not restart.
- R5: While ramping, `freq_code_o` changes by exactly one unit toward the target on each tick, and never by more than one unit per cycle.
- R6: A tick occurs every `step_div_i + 1` cycles. The tick divider restarts from zero whenever the block is not ramping, so the first step is visible `step_div_i + 1` cycles after `slewing_o` rises.
- R7: `slewing_o` is 1 exactly while the machine is in `ST_RISE` or `ST_FALL`. Outside those states `freq_code_o` does not change (except at the `ST_INIT` load).
- R8: `settled_o` is 1 exactly when, in the previous cycle, the machine was out of `ST_INIT` and the code equalled the target. It is never 1 together with `slewing_o`, and while it is 1 the code is stable.
- R9: If the target moves to the other side of the code mid-ramp, the direction flips without a step in the flip cycle, and `slewing_o` stays high.
- R10: `freq_code_o` always stays within the lower and upper limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| freq_sel_i | input | SEL_W (3) | Frequency select |
| freq_table_i | input | N_ENTRIES*CODE_W (64) | Configured frequency codes, entry k at `[k*CODE_W +: CODE_W]` |
| step_div_i | input | DIV_W (12) | Step-rate divider; tick period is value+1 cycles |
| freq_code_o | output | CODE_W (8) | Applied frequency code |
| slewing_o | output | 1 | Ramp in progress |
| settled_o | output | 1 | Code has matched the target since the previous cycle |

## Verification
The hardest cases to reach from the ports are a direction reversal and a retarget to the same side, both in the middle of a ramp. To reach them, the bench lets a long ramp run for a fixed number of cycles and then changes the select while `slewing_o` is still high. It then checks that the code never overshoots by more than one step and that `slewing_o` never drops before the new target is met. The tick-to-step spacing is measured directly from the rise of `slewing_o`. A cycle-by-cycle behavioural model, which also watches the clamped table entries and a divider of zero, is compared on every clock.

// File: rtl/cpu_slew_pkg.sv
package cpu_slew_pkg;

    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_HOLD = 2'd1,
        ST_RISE = 2'd2,
        ST_FALL = 2'd3
    } slew_state_e;

endpackage

// File: rtl/slew_tick_gen.sv
module slew_tick_gen #(
    parameter int DIV_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == div_i);
    assign tick_o = en_i && at_end;

    // Divider restarts whenever ramping is not active.
    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            cnt_q <= '0;
        end else if (at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
        end
    end

endmodule

// File: rtl/slew_target_sel.sv
module slew_target_sel #(
    parameter int CODE_W    = 8,
    parameter int N_ENTRIES = 8,
    parameter int MIN_CODE  = 8,
    parameter int MAX_CODE  = 100,
    localparam int SEL_W    = $clog2(N_ENTRIES)
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic [SEL_W-1:0]              sel_i,
    input  logic [N_ENTRIES*CODE_W-1:0]   table_i,
    output logic [CODE_W-1:0]             tgt_now_o,
    output logic [CODE_W-1:0]             tgt_q_o
);

    localparam logic [CODE_W-1:0] LO_C = CODE_W'(MIN_CODE);
    localparam logic [CODE_W-1:0] HI_C = CODE_W'(MAX_CODE);

    logic [CODE_W-1:0] clamped [N_ENTRIES];

    // One clamp per table entry.
    for (genvar k = 0; k < N_ENTRIES; k++) begin : g_clamp
        logic [CODE_W-1:0] raw;
        assign raw = table_i[k*CODE_W +: CODE_W];
        always_comb begin
            if (raw < LO_C) begin
                clamped[k] = LO_C;
            end else if (raw > HI_C) begin
                clamped[k] = HI_C;
            end else begin
                clamped[k] = raw;
            end
        end
    end

    assign tgt_now_o = clamped[sel_i];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tgt_q_o <= LO_C;
        end else begin
            tgt_q_o <= tgt_now_o;
        end
    end

endmodule

// File: rtl/slew_fsm.sv
module slew_fsm
    import cpu_slew_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int MIN_CODE = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [CODE_W-1:0] tgt_now_i,
    input  logic [CODE_W-1:0] tgt_q_i,
    input  logic              tick_i,
    output logic [CODE_W-1:0] code_o,
    output logic              busy_o,
    output logic              settled_o,
    output logic              init_o
);

    localparam logic [CODE_W-1:0] LO_C  = CODE_W'(MIN_CODE);
    localparam logic [CODE_W-1:0] ONE_C = {{(CODE_W-1){1'b0}}, 1'b1};

    slew_state_e       state_q, state_nx;
    logic [CODE_W-1:0] code_q, code_nx;

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_INIT;
            code_q  <= LO_C;
        end else begin
            state_q <= state_nx;
            code_q  <= code_nx;
        end
    end

    // Next state and next code
    always_comb begin
        state_nx = state_q;
        code_nx  = code_q;
        unique case (state_q)
            ST_INIT: begin
                code_nx  = tgt_now_i;
                state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                if (tgt_q_i > code_q) begin
                    state_nx = ST_RISE;
                end else if (tgt_q_i < code_q) begin
                    state_nx = ST_FALL;
                end
            end
            ST_RISE: begin
                if (tgt_q_i == code_q) begin
                    state_nx = ST_HOLD;
                end else if (tgt_q_i < code_q) begin
                    state_nx = ST_FALL;
                end else if (tick_i) begin
                    code_nx = code_q + ONE_C;
                end
            end
            ST_FALL: begin
                if (tgt_q_i == code_q) begin
                    state_nx = ST_HOLD;
                end else if (tgt_q_i > code_q) begin
                    state_nx = ST_RISE;
                end else if (tick_i) begin
                    code_nx = code_q - ONE_C;
                end
            end
            default: begin
                state_nx = ST_INIT;
            end
        endcase
    end

    // Outputs
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            settled_o <= 1'b0;
        end else begin
            settled_o <= (state_q != ST_INIT) && (code_q == tgt_q_i);
        end
    end

    assign busy_o = (state_q == ST_RISE) || (state_q == ST_FALL);
    assign init_o = (state_q == ST_INIT);
    assign code_o = code_q;

endmodule

// File: rtl/cpu_slew_selector.sv
module cpu_slew_selector #(
    parameter int CODE_W    = 8,
    parameter int N_ENTRIES = 8,
    parameter int DIV_W     = 12,
    parameter int MIN_CODE  = 8,
    parameter int MAX_CODE  = 100,
    localparam int SEL_W    = $clog2(N_ENTRIES)
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic [SEL_W-1:0]            freq_sel_i,
    input  logic [N_ENTRIES*CODE_W-1:0] freq_table_i,
    input  logic [DIV_W-1:0]            step_div_i,
    output logic [CODE_W-1:0]           freq_code_o,
    output logic                        slewing_o,
    output logic                        settled_o
);

    logic [CODE_W-1:0] tgt_now, tgt_q;
    logic              tick;
    logic              fsm_init;

    slew_target_sel #(
        .CODE_W   (CODE_W),
        .N_ENTRIES(N_ENTRIES),
        .MIN_CODE (MIN_CODE),
        .MAX_CODE (MAX_CODE)
    ) u_tgt (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .sel_i    (freq_sel_i),
        .table_i  (freq_table_i),
        .tgt_now_o(tgt_now),
        .tgt_q_o  (tgt_q)
    );

    slew_tick_gen #(
        .DIV_W(DIV_W)
    ) u_tick (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (slewing_o),
        .div_i (step_div_i),
        .tick_o(tick)
    );

    slew_fsm #(
        .CODE_W  (CODE_W),
        .MIN_CODE(MIN_CODE)
    ) u_fsm (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .tgt_now_i(tgt_now),
        .tgt_q_i  (tgt_q),
        .tick_i   (tick),
        .code_o   (freq_code_o),
        .busy_o   (slewing_o),
        .settled_o(settled_o),
        .init_o   (fsm_init)
    );

endmodule

// File: rtl/cpu_slew_checker.sv
module cpu_slew_checker #(
    parameter int CODE_W   = 8,
    parameter int MIN_CODE = 8,
    parameter int MAX_CODE = 100
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [CODE_W-1:0] code_i,
    input logic              busy_i,
    input logic              settled_i,
    input logic              init_i
);

    localparam logic [CODE_W-1:0] LO_C  = CODE_W'(MIN_CODE);
    localparam logic [CODE_W-1:0] HI_C  = CODE_W'(MAX_CODE);
    localparam logic [CODE_W-1:0] ONE_C = {{(CODE_W-1){1'b0}}, 1'b1};

    assert_unit_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_i |=> (code_i == $past(code_i)) || (code_i == $past(code_i) + ONE_C)
                   || (code_i + ONE_C == $past(code_i)));

    assert_in_range_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (code_i >= LO_C) && (code_i <= HI_C));

    assert_not_both_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !(busy_i && settled_i));

    assert_settled_stable_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        settled_i |-> $stable(code_i));

    assert_idle_stable_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_i && !init_i) |=> $stable(code_i));

endmodule

bind cpu_slew_selector cpu_slew_checker #(
    .CODE_W  (CODE_W),
    .MIN_CODE(MIN_CODE),
    .MAX_CODE(MAX_CODE)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .code_i   (freq_code_o),
    .busy_i   (slewing_o),
    .settled_i(settled_o),
    .init_i   (fsm_init)
);

// File: tb/sim_cpu_slew_selector.sv
`timescale 1ns/1ps
module sim_cpu_slew_selector;

    localparam int CW = 8;
    localparam int NE = 8;
    localparam int DW = 12;
    localparam int LO = 8;
    localparam int HI = 100;

    logic          clk = 1'b0;
    logic          rst;
    logic [2:0]    sel;
    logic [NE*CW-1:0] tbl;
    logic [DW-1:0] div;
    logic [CW-1:0] code;
    logic          slewing, settled;

    int checks = 0;
    int errors = 0;
    int entries [NE] = '{20, 3, 200, 40, 8, 100, 25, 60};

    always #4 clk = ~clk;

    cpu_slew_selector #(
        .CODE_W(CW), .N_ENTRIES(NE), .DIV_W(DW), .MIN_CODE(LO), .MAX_CODE(HI)
    ) u0 (
        .clk_i(clk), .rst_i(rst), .freq_sel_i(sel), .freq_table_i(tbl),
        .step_div_i(div), .freq_code_o(code), .slewing_o(slewing), .settled_o(settled)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int clampv(input int v);
        if (v < LO) return LO;
        if (v > HI) return HI;
        return v;
    endfunction

    // Behavioural reference: mode 0 init, 1 idle, 2 up, 3 down
    int m_mode, m_cur, m_tgt, m_cnt, m_settled;
    always @(posedge clk) begin
        int tnow, nc, nm;
        bit busy, tick;
        if (rst) begin
            m_mode = 0; m_cur = LO; m_tgt = LO; m_cnt = 0; m_settled = 0;
        end else begin
            tnow = clampv(entries[sel]);
            busy = (m_mode >= 2);
            tick = busy && (m_cnt == int'(div));
            nc = m_cur; nm = m_mode;
            if (m_mode == 0) begin nc = tnow; nm = 1; end
            else if (m_tgt == m_cur) nm = 1;
            else if (m_tgt > m_cur) begin
                nm = 2;
                if (m_mode == 2 && tick) nc = m_cur + 1;
            end else begin
                nm = 3;
                if (m_mode == 3 && tick) nc = m_cur - 1;
            end
            m_settled = (m_mode != 0 && m_cur == m_tgt) ? 1 : 0;
            m_cnt = (!busy || tick) ? 0 : m_cnt + 1;
            m_cur = nc; m_mode = nm; m_tgt = tnow;
        end
    end

    bit run_cmp = 0;
    always @(negedge clk) begin
        if (run_cmp && !rst) begin
            check(int'(code) == m_cur, "R5 R4 model code", int'(code), m_cur);
            check(int'(slewing) == int'(m_mode >= 2), "R7 model slewing", int'(slewing), int'(m_mode >= 2));
            check(int'(settled) == m_settled, "R8 model settled", int'(settled), m_settled);
            check(int'(code) >= LO && int'(code) <= HI, "R10 range", int'(code), LO);
        end
    end

    task automatic wait_settle(input int exp, input string req);
        int n = 0;
        repeat (3) @(negedge clk);
        while (!settled && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(settled == 1'b1, req, int'(settled), 1);
        check(int'(code) == exp, req, int'(code), exp);
    endtask

    initial begin
        #(8ns * 100000);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, c0, lo_seen;
        bit dropped;
        rst = 1'b1; sel = 3'd0; div = 12'd2;
        for (int k = 0; k < NE; k++) tbl[k*CW +: CW] = CW'(entries[k]);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(int'(code) == LO, "R1 code", int'(code), LO);
        check(slewing == 1'b0, "R1 slewing", int'(slewing), 0);
        check(settled == 1'b0, "R1 settled", int'(settled), 0);
        rst = 1'b0;
        run_cmp = 1;
        @(negedge clk);
        // R2 direct load, no ramp
        check(int'(code) == 20, "R2 direct load", int'(code), 20);
        check(settled == 1'b0, "R2 settled late", int'(settled), 0);
        @(negedge clk);
        check(settled == 1'b1, "R2 settled one cycle after", int'(settled), 1);

        // R6 first step spacing
        sel = 3'd3;
        n = 0;
        while (!slewing && n < 20) begin @(negedge clk); n++; end
        n = 0;
        while (int'(code) == 20 && n < 50) begin @(negedge clk); n++; end
        check(n == int'(div) + 1, "R6 first step delay", n, int'(div) + 1);
        // R6 second step spacing
        n = 0;
        while (int'(code) == 21 && n < 50) begin @(negedge clk); n++; end
        check(n == int'(div) + 1, "R6 step period", n, int'(div) + 1);
        wait_settle(40, "R5 ramp up to 40");

        // R3 clamp low and high
        sel = 3'd1;
        wait_settle(LO, "R3 clamp low entry");
        sel = 3'd2;
        wait_settle(HI, "R3 clamp high entry");

        // R9 reversal mid-ramp
        sel = 3'd4;
        repeat (14) @(negedge clk);
        c0 = int'(code);
        check(c0 < HI && c0 > LO, "R9 mid ramp", c0, HI - 1);
        sel = 3'd5;
        lo_seen = c0; dropped = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (int'(code) < lo_seen) lo_seen = int'(code);
            if (!slewing) dropped = 1;
        end
        check(lo_seen >= c0 - 1, "R9 no overshoot after flip", lo_seen, c0 - 1);
        check(!dropped, "R9 slewing held across flip", int'(dropped), 0);
        wait_settle(HI, "R9 back to top");

        // R4 same-side retarget, divider zero
        div = 12'd0;
        sel = 3'd6;
        repeat (20) @(negedge clk);
        c0 = int'(code);
        check(c0 > 60 && c0 < HI, "R4 mid ramp", c0, 80);
        sel = 3'd7;
        dropped = 0;
        n = 0;
        while (int'(code) != 60 && n < 500) begin
            @(negedge clk);
            if (!slewing && int'(code) != 60) dropped = 1;
            n++;
        end
        check(!dropped, "R4 ramp not restarted", int'(dropped), 0);
        check(n <= c0 - 60 + 2, "R4 one per cycle continue", n, c0 - 60);
        wait_settle(60, "R4 final code");

        repeat (4) @(negedge clk);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule